// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block is the arbitration heart of an eight-line interrupt controller. It receives a vector of pending requests and a vector of mask bits from the surrounding logic, and it holds two pieces of state: the in-service vector, which records the lines the processor has accepted but not yet finished, and a rotation offset, which names the line that currently holds the top priority. From these it works out combinationally whether the processor should be interrupted and which line would be handed over.

Priority runs cyclically. The line at the offset ranks first, and each following line, counted upward modulo eight, ranks one lower. A request is raised only when it strictly outranks everything already in service. An acknowledge strobe moves the winner into service. A three-bit command code, with a line number beside it, retires in-service lines in several ways: specific or non-specific, with or without rotation. Other codes move the offset or arm rotation on automatic end-of-interrupt. A nested-mode input lets a master instance ignore its cascade line when it judges what is in service.

Top module: `irq_rank_core`

## Requirements
- R1: After a synchronous active-low reset the in-service vector is zero, the offset is zero (line 0 highest, line 7 lowest), and rotation on automatic end-of-interrupt is disarmed.
- R2: The candidate is the unmasked pending line (pend_i=1, mask_i=0) reached first when scanning upward from the offset modulo 8. `win_line_o` reports it and is meaningful only while `irq_o` is high. Both outputs are combinational from the inputs and the registered state.
- R3: `irq_o` is high only when a candidate exists and its rank is strictly better than the best rank among in-service lines. Rank 8 means that no in-service line exists.
- R4: While `nested_i` is high, the in-service bit of the cascade line (line 2) is left out of the in-service rank that R3 compares against.
- R5: With `ack_i` high, `cmd_valid_i` low and `aeoi_i` low, the in-service bit of the winning line is set at the next clock edge if `irq_o` is high. If `irq_o` is low, the acknowledge changes nothing.
- R6: With `aeoi_i` high, an acknowledge while `irq_o` is high leaves the in-service vector unchanged. If rotation is armed, the offset becomes winner+1 (mod 8).
- R7: Codes 1 and 5 clear the in-service bit of best rank, ranked over the whole in-service vector. Code 5 also sets the offset to that line+1. When no bit is in service, neither code changes any state.
- R8: Codes 3 and 7 clear the in-service bit named by `cmd_line_i`. Code 7 also sets the offset to `cmd_line_i`+1.
- R9: Code 6 sets the offset to `cmd_line_i`+1 (mod 8) and leaves the in-service vector alone.
- R10: Code 4 arms rotation on automatic end-of-interrupt, code 0 disarms it, and code 2 changes nothing.
- R11: When `cmd_valid_i` and `ack_i` are high in the same cycle, the command is carried out and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | 8 | Pending request per line |
| mask_i | input | 8 | Mask per line, 1 blocks the line |
| ack_i | input | 1 | Acknowledge strobe from the processor side |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (0..7, see R7 to R10) |
| cmd_line_i | input | 3 | Line operand of the command |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| nested_i | input | 1 | Nested mode on a master: cascade line ignored in service |
| irq_o | output | 1 | Interrupt request to the processor |
| win_line_o | output | 3 | Winning line number |
| isr_o | output | 8 | In-service vector |

## Verification
A corrupted in-service vector shows on `isr_o` one clock after the offending strobe. It also changes `irq_o` in that same cycle, because a stale or missing in-service bit lifts or lowers the bar that every new request has to clear. A wrong rotation offset has no port of its own. It surfaces as a different `win_line_o` the first time two or more unmasked lines are pending together, so the stimulus keeps several requests live at once and checks the winner on every cycle.

// File: rtl/irq_rank_pkg.sv
// Package: shared widths and types for the rotating priority resolver.
// Assumes the line count is a power of two so that offset arithmetic wraps.
package irq_rank_pkg;

    localparam int NUM_LINES = 8;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int RANK_W    = LINE_W + 1;

    // Command codes, value fixed by the command field encoding
    typedef enum logic [2:0] {
        CODE_ROT_OFF   = 3'd0,
        CODE_EOI_ANY   = 3'd1,
        CODE_NOP       = 3'd2,
        CODE_EOI_LINE  = 3'd3,
        CODE_ROT_ON    = 3'd4,
        CODE_EOI_ANY_R = 3'd5,
        CODE_SET_OFF   = 3'd6,
        CODE_EOI_LINE_R= 3'd7
    } cmd_code_e;

    // Decoded actions of one command
    typedef struct packed {
        logic clr_best;   // retire best-ranked in-service line
        logic clr_named;  // retire the named line
        logic rotate;     // move offset past the retired line
        logic set_off;    // move offset past the named line
        logic set_rot;    // update the rotate-on-auto flag
        logic rot_val;    // value for the rotate-on-auto flag
    } cmd_act_t;

endpackage

// File: rtl/irq_rank_finder.sv
// Module: irq_rank_finder
// Finds the rank of the first set bit in a vector, scanning upward from
// a start offset with wrap-around. Rank 0 is the line at the offset;
// rank N means the vector is empty. Assumes N is a power of two.
module irq_rank_finder #(
    parameter int N  = 8,
    localparam int LW = $clog2(N),
    localparam int RW = LW + 1
) (
    input  logic [N-1:0]  vec_i,
    input  logic [LW-1:0] offset_i,
    output logic [RW-1:0] rank_o
);

    logic [N-1:0] rot;

    // Rotate so that bit k holds the line of rank k
    always_comb begin
        for (int k = 0; k < N; k++) begin
            rot[k] = vec_i[LW'(k) + offset_i];
        end
    end

    // Lowest set bit of the rotated vector gives the rank
    always_comb begin
        rank_o = RW'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) rank_o = RW'(k);
        end
    end

endmodule

// File: rtl/irq_cmd_decode.sv
// Module: irq_cmd_decode
// Turns a command code into the individual state actions. Pure
// combinational; actions are zero when the strobe is low.
module irq_cmd_decode
    import irq_rank_pkg::*;
(
    input  logic       valid_i,
    input  logic [2:0] code_i,
    output cmd_act_t   act_o
);

    // Map each code onto its set of actions
    always_comb begin
        act_o = '0;
        if (valid_i) begin
            unique case (cmd_code_e'(code_i))
                CODE_ROT_OFF:    begin act_o.set_rot = 1'b1; act_o.rot_val = 1'b0; end
                CODE_ROT_ON:     begin act_o.set_rot = 1'b1; act_o.rot_val = 1'b1; end
                CODE_EOI_ANY:    act_o.clr_best = 1'b1;
                CODE_EOI_ANY_R:  begin act_o.clr_best = 1'b1; act_o.rotate = 1'b1; end
                CODE_EOI_LINE:   act_o.clr_named = 1'b1;
                CODE_EOI_LINE_R: begin act_o.clr_named = 1'b1; act_o.rotate = 1'b1; end
                CODE_SET_OFF:    act_o.set_off = 1'b1;
                CODE_NOP:        act_o = '0;
                default:         act_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_rank_core.sv
// Module: irq_rank_core
// Priority and in-service core of an interrupt controller. Holds the
// in-service vector, the rotation offset and the rotate-on-auto flag,
// raises a request when the best pending line strictly outranks all
// in-service lines, and updates state on acknowledge and commands.
// Assumes pend_i and mask_i are held by the surrounding logic, and that
// nested_i is driven high only on a master instance.
module irq_rank_core
    import irq_rank_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 ack_i,
    input  logic                 cmd_valid_i,
    input  logic [2:0]           cmd_code_i,
    input  logic [LINE_W-1:0]    cmd_line_i,
    input  logic                 aeoi_i,
    input  logic                 nested_i,
    output logic                 irq_o,
    output logic [LINE_W-1:0]    win_line_o,
    output logic [NUM_LINES-1:0] isr_o
);

    localparam logic [NUM_LINES-1:0] CASCADE_BIT = NUM_LINES'(1) << CASCADE_LINE;

    logic [NUM_LINES-1:0] isr_q, isr_n;
    logic [LINE_W-1:0]    off_q, off_n;
    logic                 rot_q, rot_n;

    logic [NUM_LINES-1:0] req_vec, cur_vec;
    logic [RANK_W-1:0]    req_rank, cur_rank, all_rank;
    logic [LINE_W-1:0]    best_isr_line;
    logic                 best_isr_hit;
    cmd_act_t             act;

    // Candidates are unmasked pending lines
    assign req_vec = pend_i & ~mask_i;
    // In-service bits that set the bar, cascade left out in nested mode
    assign cur_vec = nested_i ? (isr_q & ~CASCADE_BIT) : isr_q;

    irq_rank_finder #(.N(NUM_LINES)) u_req_rank (
        .vec_i(req_vec), .offset_i(off_q), .rank_o(req_rank)
    );
    irq_rank_finder #(.N(NUM_LINES)) u_cur_rank (
        .vec_i(cur_vec), .offset_i(off_q), .rank_o(cur_rank)
    );
    irq_rank_finder #(.N(NUM_LINES)) u_all_rank (
        .vec_i(isr_q), .offset_i(off_q), .rank_o(all_rank)
    );

    irq_cmd_decode u_decode (
        .valid_i(cmd_valid_i), .code_i(cmd_code_i), .act_o(act)
    );

    // Request only when a candidate strictly outranks in-service lines
    assign irq_o         = !req_rank[RANK_W-1] && (req_rank < cur_rank);
    assign win_line_o    = req_rank[LINE_W-1:0] + off_q;
    assign best_isr_hit  = !all_rank[RANK_W-1];
    assign best_isr_line = all_rank[LINE_W-1:0] + off_q;
    assign isr_o         = isr_q;

    // Next-state selection: a command takes precedence over acknowledge
    always_comb begin
        isr_n = isr_q;
        off_n = off_q;
        rot_n = rot_q;
        if (cmd_valid_i) begin
            if (act.set_rot) rot_n = act.rot_val;
            if (act.clr_best && best_isr_hit) begin
                isr_n[best_isr_line] = 1'b0;
                if (act.rotate) off_n = best_isr_line + LINE_W'(1);
            end
            if (act.clr_named) begin
                isr_n[cmd_line_i] = 1'b0;
                if (act.rotate) off_n = cmd_line_i + LINE_W'(1);
            end
            if (act.set_off) off_n = cmd_line_i + LINE_W'(1);
        end else if (ack_i && irq_o) begin
            if (aeoi_i) begin
                if (rot_q) off_n = win_line_o + LINE_W'(1);
            end else begin
                isr_n[win_line_o] = 1'b1;
            end
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            off_q <= '0;
            rot_q <= 1'b0;
        end else begin
            isr_q <= isr_n;
            off_q <= off_n;
            rot_q <= rot_n;
        end
    end

    // Assertions guarding the state updates
    AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_i[win_line_o] && !mask_i[win_line_o])); // R2
    AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !nested_i) |-> !isr_o[win_line_o]); // R3
    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !cmd_valid_i && !aeoi_i) |=> isr_o[$past(win_line_o)]); // R5
    AST_AUTO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cmd_valid_i && aeoi_i) |=> $stable(isr_o)); // R6
    AST_EOI_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_code_i == 3'd1 || cmd_code_i == 3'd5) && isr_o == '0)
        |=> (isr_o == '0 && $stable(off_q))); // R7
    AST_NAMED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_code_i == 3'd3 || cmd_code_i == 3'd7))
        |=> !isr_o[$past(cmd_line_i)]); // R8
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 3'd2) |=> ($stable(isr_o) && $stable(off_q))); // R10

endmodule

// File: tb/irq_rank_core_bench.sv
// Bench for irq_rank_core: directed corner cases followed by seeded
// random traffic, all compared with a bench-side model of the rules.
module irq_rank_core_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pend, mask;
    logic       ack, cmd_v, aeoi, nest;
    logic [2:0] code, line;
    logic       irq_o;
    logic [2:0] win_line_o;
    logic [7:0] isr_o;

    int n_vec = 0;
    int n_bad = 0;

    // Model state
    logic [7:0] m_isr;
    logic [2:0] m_off;
    logic       m_rot;

    always #5 clk = ~clk;

    irq_rank_core u_irq_rank_core (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask),
        .ack_i(ack), .cmd_valid_i(cmd_v), .cmd_code_i(code),
        .cmd_line_i(line), .aeoi_i(aeoi), .nested_i(nest),
        .irq_o(irq_o), .win_line_o(win_line_o), .isr_o(isr_o)
    );

    // Rank by linear scan from the offset; 8 when empty
    function automatic int rank_of(input logic [7:0] v, input logic [2:0] off);
        for (int k = 0; k < 8; k++) begin
            if (v[(k + off) % 8]) return k;
        end
        return 8;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against model, advance model
    task automatic step(input logic [7:0] p, input logic [7:0] m, input logic a,
                        input logic cv, input logic [2:0] cc, input logic [2:0] cl,
                        input logic ae, input logic ns, input string tag);
        int pr, cr, br;
        logic e_irq;
        logic [2:0] e_win, bl;
        logic [7:0] cv_isr;
        @(negedge clk);
        pend = p; mask = m; ack = a; cmd_v = cv; code = cc; line = cl;
        aeoi = ae; nest = ns;
        #1;
        check(isr_o == m_isr, tag, "isr", isr_o, m_isr);
        cv_isr = ns ? (m_isr & 8'hFB) : m_isr;
        pr = rank_of(p & ~m, m_off);
        cr = rank_of(cv_isr, m_off);
        e_irq = (pr < 8) && (pr < cr);
        e_win = 3'((pr + m_off) % 8);
        check(irq_o == e_irq, tag, "irq", irq_o, e_irq);
        if (e_irq) check(win_line_o == e_win, tag, "win", win_line_o, e_win);
        if (cv) begin
            br = rank_of(m_isr, m_off);
            bl = 3'((br + m_off) % 8);
            case (cc)
                3'd0: m_rot = 1'b0;
                3'd4: m_rot = 1'b1;
                3'd1, 3'd5: if (br < 8) begin
                    m_isr[bl] = 1'b0;
                    if (cc == 3'd5) m_off = bl + 3'd1;
                end
                3'd3: m_isr[cl] = 1'b0;
                3'd7: begin m_isr[cl] = 1'b0; m_off = cl + 3'd1; end
                3'd6: m_off = cl + 3'd1;
                default: ;
            endcase
        end else if (a && e_irq) begin
            if (ae) begin
                if (m_rot) m_off = e_win + 3'd1;
            end else begin
                m_isr[e_win] = 1'b1;
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; pend = '0; mask = '0; ack = 0; cmd_v = 0;
        code = '0; line = '0; aeoi = 0; nest = 0;
        m_isr = '0; m_off = '0; m_rot = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, line 0 is top priority
        step(8'h81, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R1");
        step(8'h80, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R1 R2");
        step(8'h81, 8'h01, 0, 0, 3'd0, 3'd0, 0, 0, "R2");
        // R9: code 6 with line 3 moves top priority to line 4
        step(8'h00, 8'h00, 0, 1, 3'd6, 3'd3, 0, 0, "R9");
        step(8'h81, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R9 R2");
        // R5: acknowledge with no request does nothing
        step(8'h00, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0, "R5");
        step(8'h10, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0, "R5");
        // R3: line 5 ranks below in-service line 4
        step(8'h20, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R5 R3");
        step(8'h10, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R3");
        // R8: retire line 4 by name, then restore offset 0
        step(8'h00, 8'h00, 0, 1, 3'd3, 3'd4, 0, 0, "R8");
        step(8'h00, 8'h00, 0, 1, 3'd6, 3'd7, 0, 0, "R8 R9");
        // R4: cascade line in service
        step(8'h04, 8'h00, 1, 0, 3'd0, 3'd0, 0, 0, "R4");
        step(8'h04, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R4 R3");
        step(8'h04, 8'h00, 0, 0, 3'd0, 3'd0, 0, 1, "R4");
        step(8'h08, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R4 R3");
        step(8'h08, 8'h00, 0, 0, 3'd0, 3'd0, 0, 1, "R4");
        // R7: non-specific retire, then on empty vector
        step(8'h00, 8'h00, 0, 1, 3'd5, 3'd0, 0, 0, "R7");
        step(8'h03, 8'h00, 0, 1, 3'd1, 3'd0, 0, 0, "R7");
        step(8'h03, 8'h00, 0, 1, 3'd5, 3'd0, 0, 0, "R7");
        step(8'h03, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R7 R2");
        // R10, R6: arm rotation, automatic acknowledge on line 1
        step(8'h00, 8'h00, 0, 1, 3'd6, 3'd7, 0, 0, "R10");
        step(8'h00, 8'h00, 0, 1, 3'd4, 3'd0, 0, 0, "R10");
        step(8'h02, 8'h00, 1, 0, 3'd0, 3'd0, 1, 0, "R6");
        step(8'h03, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R6 R10");
        step(8'h00, 8'h00, 0, 1, 3'd2, 3'd5, 0, 0, "R10");
        step(8'h00, 8'h00, 0, 1, 3'd0, 3'd0, 0, 0, "R10");
        step(8'h02, 8'h00, 1, 0, 3'd0, 3'd0, 1, 0, "R10 R6");
        step(8'h03, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R10 R6");
        // R11: command and acknowledge together
        step(8'h01, 8'h00, 1, 1, 3'd2, 3'd0, 0, 0, "R11");
        step(8'h01, 8'h00, 1, 1, 3'd6, 3'd1, 0, 0, "R11");
        step(8'h01, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R11");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] rp, rm;
            logic [2:0] rc, rl;
            logic ra, rv, rae, rns;
            rp  = 8'($urandom);
            rm  = 8'($urandom) & 8'($urandom);
            ra  = ($urandom % 2) == 0;
            rv  = ($urandom % 5) == 0;
            rc  = 3'($urandom);
            rl  = 3'($urandom);
            rae = ($urandom % 4) == 0;
            rns = ($urandom % 4) == 0;
            step(rp, rm, ra, rv, rc, rl, rae, rns, "R2 R3 R5 R6 R7 R8 R9 R10 R11");
        end
        step(8'h00, 8'h00, 0, 0, 3'd0, 3'd0, 0, 0, "R5 R7 R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule